// File: doc/BRIEF.md
# Way-and-Set-Group Recency Counter Array

This block watches the access stream of a set-associative cache and builds a two-dimensional histogram of reuse distance. It keeps two recency orders. The first ranks the ways inside each set, with rank 0 as the most recently used way. The second ranks fixed groups of consecutive sets against each other. On a hit, the block finds the hit way's rank inside its set and the rank of that set's group, then adds one to the counter at that (way-rank, group-rank) pair. After that it moves both the way and the group to the front of their orders. Software or a scheduler can read the pairs and build a miss-rate curve with a finer step than a plain per-way count gives. That conversion happens outside this block.

Every access (hit or miss) also counts toward a running total. A miss reorders the set as if the least recent way had been refilled, but it does not touch any pair counter. A clear input zeroes every count and leaves both recency orders as they are. Each access takes effect in one clock cycle, and the read port returns any counter combinationally.

Top module: `wsg_recency_monitor`

## Requirements
- R1: After reset, every pair counter and the total are zero. Way `w` of every set holds way-rank `w`, and group `g` holds group-rank `g`.
- R2: Each cycle with `accValid` high and `clrReq` low adds one to `totalCount`, whether the access is a hit or a miss.
- R3: A hit on a way whose current way-rank is `i`, in a set whose group has current group-rank `j`, adds one to counter (`i`,`j`). No other pair counter changes.
- R4: The group of a set is `accSet / (NUM_SETS/NUM_GROUPS)`. Any access moves that group to rank 0. Every group whose rank was below the old rank of the accessed group moves down by one. All other groups keep their rank.
- R5: A hit moves the hit way to rank 0 in its set. Ways that ranked ahead of it move down by one, and the other ways keep their rank.
- R6: A miss changes no pair counter. The way holding rank `NUM_WAYS-1` in that set moves to rank 0, and the other ways of the set move down by one.
- R7: Every pair counter and the total stop at the all-ones value and never wrap.
- R8: `clrReq` high zeroes all pair counters and the total on the next edge, and neither recency order changes because of it. An access in the same cycle still updates both orders but adds no count.
- R9: `rdCount` shows counter (`rdWayRank`, `rdGrpRank`) in the same cycle. Rank 0 means most recently used.
- R10: A cycle with `accValid` and `clrReq` both low changes no counter and no order, whatever the other access inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accSet | input | $clog2(NUM_SETS) | Set index of the access |
| accHit | input | 1 | Access hit in the cache |
| accWay | input | $clog2(NUM_WAYS) | Way that hit (ignored on a miss) |
| clrReq | input | 1 | Zero all counters |
| rdWayRank | input | $clog2(NUM_WAYS) | Way-rank coordinate to read |
| rdGrpRank | input | $clog2(NUM_GROUPS) | Group-rank coordinate to read |
| rdCount | output | CNT_W | Selected pair counter |
| totalCount | output | CNT_W | Count of all accesses since the last clear |

## Verification
Two instances run side by side on the same stimulus, one with 8 groups and one with 16. The same set index therefore lands on different group ranks in each, which separates a wrong set-to-group mapping from a wrong group order. Directed hits on a fresh state hit the extreme ranks: the last group, the second way, and a hit right after a miss refill. These show whether both ranks are taken before the orders move, and whether a miss picks the least recent way. Random runs cover repeated touches of a small pool of sets, spread accesses across all sets, idle cycles, and clears that coincide with an access. They are checked against a reference model, and a narrow counter width in the bench brings saturation within reach.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  // Strobes passed from the ordering control to the counter datapath.
  typedef struct packed {
    logic clrAll;    // zero every counter
    logic incTotal;  // count one access
    logic incPair;   // count one hit at the presented rank pair
  } wsgStrobe_t;

endpackage

// File: rtl/wsg_order_ctrl.sv
module wsg_order_ctrl
  import wsg_pkg::*;
#(
  parameter int NUM_WAYS   = 2,
  parameter int NUM_SETS   = 64,
  parameter int NUM_GROUPS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          accValid,
  input  logic [$clog2(NUM_SETS)-1:0]   accSet,
  input  logic                          accHit,
  input  logic [$clog2(NUM_WAYS)-1:0]   accWay,
  input  logic                          clrReq,
  output wsgStrobe_t                    strb,
  output logic [$clog2(NUM_WAYS)-1:0]   pairWayRank,
  output logic [$clog2(NUM_GROUPS)-1:0] pairGrpRank
);

  localparam int WAY_W        = $clog2(NUM_WAYS);
  localparam int SET_W        = $clog2(NUM_SETS);
  localparam int GRP_W        = $clog2(NUM_GROUPS);
  localparam int SETS_PER_GRP = NUM_SETS / NUM_GROUPS;

  logic [WAY_W-1:0] wayRankMem [NUM_SETS][NUM_WAYS];
  logic [GRP_W-1:0] grpRankMem [NUM_GROUPS];

  logic [GRP_W-1:0] accGrp;
  logic [WAY_W-1:0] victimWay;
  logic [WAY_W-1:0] touchWay;
  logic [WAY_W-1:0] touchRank;
  logic [GRP_W-1:0] grpRankNow;

  // Group of a set: set index divided by the sets per group.
  assign accGrp = GRP_W'(accSet / SET_W'(SETS_PER_GRP));

  always_comb begin
    victimWay = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (wayRankMem[accSet][w] == WAY_W'(NUM_WAYS - 1)) victimWay = WAY_W'(w);
    end
    touchWay   = accHit ? accWay : victimWay;
    touchRank  = wayRankMem[accSet][touchWay];
    grpRankNow = grpRankMem[accGrp];
  end

  // Move-to-front update of the per-set way order.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          wayRankMem[s][w] <= WAY_W'(w);
    end else if (accValid) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (touchWay == WAY_W'(w))
          wayRankMem[accSet][w] <= '0;
        else if (wayRankMem[accSet][w] < touchRank)
          wayRankMem[accSet][w] <= wayRankMem[accSet][w] + 1'b1;
      end
    end
  end

  // Move-to-front update of the group order.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NUM_GROUPS; g++) grpRankMem[g] <= GRP_W'(g);
    end else if (accValid) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (accGrp == GRP_W'(g))
          grpRankMem[g] <= '0;
        else if (grpRankMem[g] < grpRankNow)
          grpRankMem[g] <= grpRankMem[g] + 1'b1;
      end
    end
  end

  always_comb begin
    strb.clrAll   = clrReq;
    strb.incTotal = accValid & ~clrReq;
    strb.incPair  = accValid & accHit & ~clrReq;
    pairWayRank   = touchRank;
    pairGrpRank   = grpRankNow;
  end

  logic [NUM_GROUPS-1:0] grpAtFront;
  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) grpAtFront[g] = (grpRankMem[g] == '0);
  end

  assert_grp_front_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accValid |=> grpRankMem[$past(accGrp)] == '0);

  assert_one_grp_mru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grpAtFront) == 1);

  assert_way_front_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accValid && accHit |=> wayRankMem[$past(accSet)][$past(accWay)] == '0);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !accValid |=> grpRankMem[$past(accGrp)] == $past(grpRankNow));

endmodule

// File: rtl/wsg_count_array.sv
module wsg_count_array
  import wsg_pkg::*;
#(
  parameter int NUM_WAYS   = 2,
  parameter int NUM_GROUPS = 8,
  parameter int CNT_W      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  wsgStrobe_t                    strb,
  input  logic [$clog2(NUM_WAYS)-1:0]   pairWayRank,
  input  logic [$clog2(NUM_GROUPS)-1:0] pairGrpRank,
  input  logic [$clog2(NUM_WAYS)-1:0]   rdWayRank,
  input  logic [$clog2(NUM_GROUPS)-1:0] rdGrpRank,
  output logic [CNT_W-1:0]              rdCount,
  output logic [CNT_W-1:0]              totalCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] pairCnt [NUM_WAYS][NUM_GROUPS];

  always_ff @(posedge clk) begin
    if (!rst_n || strb.clrAll) begin
      for (int i = 0; i < NUM_WAYS; i++)
        for (int j = 0; j < NUM_GROUPS; j++)
          pairCnt[i][j] <= '0;
    end else if (strb.incPair && pairCnt[pairWayRank][pairGrpRank] != CNT_MAX) begin
      pairCnt[pairWayRank][pairGrpRank] <= pairCnt[pairWayRank][pairGrpRank] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strb.clrAll)
      totalCount <= '0;
    else if (strb.incTotal && totalCount != CNT_MAX)
      totalCount <= totalCount + 1'b1;
  end

  assign rdCount = pairCnt[rdWayRank][rdGrpRank];

  assert_total_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.incTotal && totalCount != CNT_MAX |=> totalCount == $past(totalCount) + 1'b1);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    totalCount == CNT_MAX && !strb.clrAll |=> totalCount == CNT_MAX);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrAll |=> totalCount == '0);

  assert_pair_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.incPair && pairCnt[pairWayRank][pairGrpRank] != CNT_MAX
    |=> pairCnt[$past(pairWayRank)][$past(pairGrpRank)]
        == $past(pairCnt[pairWayRank][pairGrpRank]) + 1'b1);

endmodule

// File: rtl/wsg_recency_monitor.sv
module wsg_recency_monitor
  import wsg_pkg::*;
#(
  parameter int NUM_WAYS   = 2,
  parameter int NUM_SETS   = 64,
  parameter int NUM_GROUPS = 8,
  parameter int CNT_W      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          accValid,
  input  logic [$clog2(NUM_SETS)-1:0]   accSet,
  input  logic                          accHit,
  input  logic [$clog2(NUM_WAYS)-1:0]   accWay,
  input  logic                          clrReq,
  input  logic [$clog2(NUM_WAYS)-1:0]   rdWayRank,
  input  logic [$clog2(NUM_GROUPS)-1:0] rdGrpRank,
  output logic [CNT_W-1:0]              rdCount,
  output logic [CNT_W-1:0]              totalCount
);

  wsgStrobe_t                    strb;
  logic [$clog2(NUM_WAYS)-1:0]   pairWayRank;
  logic [$clog2(NUM_GROUPS)-1:0] pairGrpRank;

  wsg_order_ctrl #(
    .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .NUM_GROUPS(NUM_GROUPS)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accSet(accSet),
    .accHit(accHit), .accWay(accWay), .clrReq(clrReq), .strb(strb),
    .pairWayRank(pairWayRank), .pairGrpRank(pairGrpRank)
  );

  wsg_count_array #(
    .NUM_WAYS(NUM_WAYS), .NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W)
  ) i_cnt (
    .clk(clk), .rst_n(rst_n), .strb(strb), .pairWayRank(pairWayRank),
    .pairGrpRank(pairGrpRank), .rdWayRank(rdWayRank), .rdGrpRank(rdGrpRank),
    .rdCount(rdCount), .totalCount(totalCount)
  );

endmodule

// File: tb/test_wsg_recency_monitor.sv
module test_wsg_recency_monitor;

  localparam int CW   = 8;
  localparam int CMAX = 255;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       accValid = 1'b0, accHit = 1'b0, clrReq = 1'b0;
  logic [5:0] accSet = '0;
  logic       accWay = 1'b0;
  logic       rdWay0 = 1'b0, rdWay1 = 1'b0;
  logic [2:0] rdGrp0 = '0;
  logic [3:0] rdGrp1 = '0;
  logic [CW-1:0] rdCnt0, rdCnt1, tot0, tot1;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  // Reference state, index 0: 8 groups, index 1: 16 groups.
  int mWay [2][64][2];
  int mGrp [2][16];
  int mCnt [2][2][16];
  int mTot [2];

  always #10 clk = ~clk;

  wsg_recency_monitor #(.NUM_WAYS(2), .NUM_SETS(64), .NUM_GROUPS(8), .CNT_W(CW))
  i_wsg_recency_monitor (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accSet(accSet), .accHit(accHit),
    .accWay(accWay), .clrReq(clrReq), .rdWayRank(rdWay0), .rdGrpRank(rdGrp0),
    .rdCount(rdCnt0), .totalCount(tot0));

  wsg_recency_monitor #(.NUM_WAYS(2), .NUM_SETS(64), .NUM_GROUPS(16), .CNT_W(CW))
  i_wsg_recency_monitor_g16 (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accSet(accSet), .accHit(accHit),
    .accWay(accWay), .clrReq(clrReq), .rdWayRank(rdWay1), .rdGrpRank(rdGrp1),
    .rdCount(rdCnt1), .totalCount(tot1));

  function automatic int numGroups(int d);
    return (d == 0) ? 8 : 16;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int d = 0; d < 2; d++) begin
      mTot[d] = 0;
      for (int s = 0; s < 64; s++) for (int w = 0; w < 2; w++) mWay[d][s][w] = w;
      for (int g = 0; g < 16; g++) mGrp[d][g] = g;
      for (int i = 0; i < 2; i++) for (int j = 0; j < 16; j++) mCnt[d][i][j] = 0;
    end
  endtask

  task automatic modelStep(bit v, int set, bit hit, int way, bit clr);
    for (int d = 0; d < 2; d++) begin
      int g, j, tw, i;
      g = set / (64 / numGroups(d));
      j = mGrp[d][g];
      tw = way;
      if (!hit) begin
        for (int w = 0; w < 2; w++) if (mWay[d][set][w] == 1) tw = w;
      end
      i = mWay[d][set][tw];
      if (clr) begin
        mTot[d] = 0;
        for (int a = 0; a < 2; a++) for (int b = 0; b < 16; b++) mCnt[d][a][b] = 0;
      end else if (v) begin
        if (mTot[d] < CMAX) mTot[d]++;
        if (hit && mCnt[d][i][j] < CMAX) mCnt[d][i][j]++;
      end
      if (v) begin
        for (int w = 0; w < 2; w++) begin
          if (w == tw) mWay[d][set][w] = 0;
          else if (mWay[d][set][w] < i) mWay[d][set][w]++;
        end
        for (int q = 0; q < numGroups(d); q++) begin
          if (q == g) mGrp[d][q] = 0;
          else if (mGrp[d][q] < j) mGrp[d][q]++;
        end
      end
    end
  endtask

  task automatic doAcc(bit v, int set, bit hit, int way, bit clr);
    @(negedge clk);
    accValid = v; accSet = 6'(set); accHit = hit; accWay = way[0]; clrReq = clr;
    @(posedge clk);
    modelStep(v, set, hit, way, clr);
    #1;
    accValid = 1'b0; clrReq = 1'b0;
  endtask

  task automatic readPair(int d, int i, int j, output int v);
    if (d == 0) begin rdWay0 = i[0]; rdGrp0 = 3'(j); end
    else begin rdWay1 = i[0]; rdGrp1 = 4'(j); end
    #1;
    v = (d == 0) ? int'(rdCnt0) : int'(rdCnt1);
  endtask

  // Full comparison of every counter through the read port (R9) and the total.
  task automatic checkAll(string tag);
    int v;
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < 2; i++)
        for (int j = 0; j < numGroups(d); j++) begin
          readPair(d, i, j, v);
          check(v == mCnt[d][i][j], {tag, " R9 pair"}, v, mCnt[d][i][j]);
        end
      v = (d == 0) ? int'(tot0) : int'(tot1);
      check(v == mTot[d], {tag, " total"}, v, mTot[d]);
    end
  endtask

  task automatic expectPair(int d, int i, int j, int exp, string tag);
    int v;
    readPair(d, i, j, v);
    check(v == exp, tag, v, exp);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    checkAll("R1 reset");

    // Directed ordering cases; fresh orders give known ranks (R1, R3, R4, R5).
    doAcc(1, 0, 1, 0, 0);
    expectPair(0, 0, 0, 1, "R3 first hit way0 group0");
    doAcc(1, 0, 1, 1, 0);
    expectPair(0, 1, 0, 1, "R5 way1 at rank1");
    doAcc(1, 63, 1, 0, 0);
    expectPair(0, 0, 7, 1, "R4 last group rank7 (8 groups)");
    expectPair(1, 0, 15, 1, "R4 last group rank15 (16 groups)");
    doAcc(1, 0, 1, 0, 0);
    expectPair(0, 1, 1, 1, "R4 R5 way0 rank1 group0 rank1");
    expectPair(1, 1, 1, 1, "R4 R5 g16 way0 rank1 group0 rank1");
    // R6: a miss fills the least recent way (way1 in a fresh set) and counts no pair.
    doAcc(1, 8, 0, 0, 0);
    checkAll("R6 miss no pair");
    doAcc(1, 8, 1, 1, 0);
    expectPair(0, 0, 0, 2, "R6 refilled way at rank0");
    checkAll("R2 R6 after refill");

    // R10: idle cycles with garbage access inputs change nothing.
    for (int k = 0; k < 6; k++) doAcc(0, $urandom_range(0, 63), $urandom_range(0, 1), $urandom_range(0, 1), 0);
    checkAll("R10 idle");
    doAcc(1, 8, 1, 1, 0);
    expectPair(0, 0, 0, 3, "R10 orders kept over idle");

    // R8: clear with a simultaneous access; orders still move.
    doAcc(1, 0, 1, 1, 1);
    checkAll("R8 clear");
    doAcc(1, 0, 1, 1, 0);
    expectPair(0, 0, 0, 1, "R8 access during clear reordered");
    checkAll("R8 after clear");

    // R7: saturation of a pair counter and the total.
    for (int k = 0; k < 300; k++) doAcc(1, 5, 1, 0, 0);
    expectPair(0, 0, 0, CMAX, "R7 pair saturates");
    checkAll("R7 saturate");
    doAcc(0, 0, 0, 0, 1);
    checkAll("R8 clear only");

    // Random runs: small set pool, then full range, with idles and clears.
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 150; k++) begin
        int set, p;
        set = (r % 2 == 0) ? $urandom_range(0, 3) * 9 : $urandom_range(0, 63);
        p = $urandom_range(0, 99);
        doAcc(p >= 10, set, $urandom_range(0, 99) < 70, $urandom_range(0, 1), p < 2);
        if (k % 15 == 14) checkAll("R3 R4 R5 R6 random");
      end
      checkAll("R2 R3 random end");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule